// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a small byte-wide serial EEPROM. A host selects it by pulling chip select low, shifts in an 8-bit opcode and then, depending on the command, address bytes, data bytes or a status byte. Six commands are understood. Two of them set or clear a write-enable latch, two read or load a status register, and two read or program the storage array. Read data leaves on a serial output, most significant bit first. Program commands are buffered and take effect only when chip select returns high on a whole-byte boundary. That edge then starts a self-timed busy period whose length is a clock-cycle count.

All pins are sampled by a single system clock that runs much faster than the serial clock. Serial clock and chip select edges are found by comparing each sample with the one before it. The array is a register file with a page buffer in front of it. A two-bit protection level in the status register write-locks the top quarter, the top half or the whole array. The output is a data bit plus an enable, so the pad can be tri-stated outside the block.

Top module: `spi_eeprom`

## Requirements
- R1: The upper nibble of an opcode must be 0000 and bit 3 is ignored. The low three bits select the command: 110 sets the write-enable latch, 100 clears it, 101 reads status, 001 loads status, 011 reads the array and 010 programs it. The encodings 000 and 111 are unrecognised.
- R2: Opcode, address and data are shifted MSB first. The input is captured on the serial clock rising edge and the output changes on the falling edge, so SPI modes 0 and 3 both work. The output enable is low whenever chip select is high.
- R3: After an unrecognised opcode, no more bytes are accepted and the output enable stays low until chip select falls again.
- R4: After reset the bus is ignored until a falling edge of chip select is seen, even if chip select is already low when reset is released.
- R5: The write-enable latch is 0 after reset. A program or status-load command that arrives while the latch is 0 is ignored.
- R6: A program command takes any number of data bytes. The byte address wraps inside its 32-byte page, so with more than 32 bytes the last value written to each location wins.
- R7: An array read auto-increments the address and rolls over from the last location to location 0.
- R8: A buffered program or status load is committed only when chip select rises with a whole number of bytes received after the address (at least one byte). The commit starts a busy period of WRITE_CYCLES clocks, and the latch clears when that period ends.
- R9: The status byte is {0000, protect[1:0], latch, busy}, with busy in bit 0. It reads 8'hFF while the busy period runs. A status load takes its protect level from bits 3:2 of the data byte.
- R10: A low write-protect pin at any time while chip select is low cancels the pending commit. A low write-protect pin during the busy period has no effect.
- R11: Protect level 1 blocks writes to the top quarter of the array, level 2 blocks the top half and level 3 blocks all of it. Bytes in a blocked region are left unchanged.
- R12: During the busy period only the status read is accepted. Every other opcode is ignored, and no output is driven for it.
- R13: The address is one byte when ADDR_W is 8 or less and two bytes otherwise. Address bits above ADDR_W are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample every pin |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| wpN | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for so |

## Verification
Most internal faults in this block appear at the serial port within one frame. A wrong write-enable latch or busy bit, or a wrong protect level, shows up in the next status read, at the output bit that carries that field. A bad address counter or a bad page-wrap rule returns the wrong byte on the first read of the affected location. This is why every program test is followed by a status read, and then by a read-back once the busy period is over. A faulty commit condition is different: it leaves the array unchanged with busy still 0. That is visible at once in a status read, since the byte shows no busy and the latch still set.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic shiftIn;
    logic addrByte;
    logic pageStart;
    logic dataByte;
    logic statByte;
    logic loadArr;
    logic loadStat;
    logic shiftOut;
    logic commitPage;
    logic writeStat;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_RD, S_WR, S_RDSR, S_WRSR, S_LOCK
  } state_t;

  localparam logic [2:0] OP_SETWEL = 3'b110;
  localparam logic [2:0] OP_CLRWEL = 3'b100;
  localparam logic [2:0] OP_RDSTAT = 3'b101;
  localparam logic [2:0] OP_WRSTAT = 3'b001;
  localparam logic [2:0] OP_RDARR  = 3'b011;
  localparam logic [2:0] OP_WRARR  = 3'b010;

endpackage

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_BYTES   = 1,
  parameter int WRITE_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       wpN,
  input  logic [7:0] rxByte,
  output strobe_t    strb,
  output logic       wel,
  output logic       busy,
  output logic       soOe
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic sckQ, csQ;
  logic sckRise, sckFall, csFall, csRise;
  state_t state, opNext;
  logic [2:0] bitCnt;
  logic addrCnt, lastAddr;
  logic isWrite, txLoad, dataSeen, statGot, cancel;
  logic [CNT_W-1:0] busyCnt;
  logic rxActive, byteDone, commitOk;

  // edge detection against the previous sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      csQ  <= 1'b0;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
    end
  end

  assign sckRise = sck & ~sckQ;
  assign sckFall = ~sck & sckQ;
  assign csFall  = ~csN & csQ;
  assign csRise  = csN & ~csQ;

  function automatic logic isOp(logic [7:0] b, logic [2:0] code);
    return (b & 8'hF7) == {5'b00000, code};
  endfunction

  always_comb begin
    opNext = S_LOCK;
    if (isOp(rxByte, OP_RDSTAT))                     opNext = S_RDSR;
    else if (isOp(rxByte, OP_WRSTAT) && wel && !busy) opNext = S_WRSR;
    else if (isOp(rxByte, OP_RDARR) && !busy)        opNext = S_ADDR;
    else if (isOp(rxByte, OP_WRARR) && wel && !busy) opNext = S_ADDR;
  end

  assign rxActive = (state == S_OPC) || (state == S_ADDR) || (state == S_RD) ||
                    (state == S_WR) || (state == S_RDSR) || (state == S_WRSR);
  assign byteDone = sckRise && rxActive && !csN && (bitCnt == 3'd7);
  assign lastAddr = (addrCnt == 1'(ADDR_BYTES - 1));
  assign commitOk = csRise && (bitCnt == 3'd0) && !cancel && wpN;

  always_comb begin
    strb            = '0;
    strb.shiftIn    = sckRise && rxActive && !csN;
    strb.addrByte   = byteDone && (state == S_ADDR);
    strb.pageStart  = byteDone && (state == S_ADDR) && lastAddr && isWrite;
    strb.dataByte   = byteDone && (state == S_WR);
    strb.statByte   = byteDone && (state == S_WRSR);
    strb.loadArr    = sckFall && txLoad && !csN && (state == S_RD);
    strb.loadStat   = sckFall && txLoad && !csN && (state == S_RDSR);
    strb.shiftOut   = sckFall && !txLoad && !csN && soOe;
    strb.commitPage = commitOk && (state == S_WR) && dataSeen;
    strb.writeStat  = commitOk && (state == S_WRSR) && statGot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      addrCnt  <= 1'b0;
      isWrite  <= 1'b0;
      txLoad   <= 1'b0;
      soOe     <= 1'b0;
      dataSeen <= 1'b0;
      statGot  <= 1'b0;
      cancel   <= 1'b0;
      wel      <= 1'b0;
      busy     <= 1'b0;
      busyCnt  <= '0;
    end else begin
      // self-timed cycle
      if (strb.commitPage || strb.writeStat) begin
        busy    <= 1'b1;
        busyCnt <= CNT_W'(WRITE_CYCLES - 1);
      end else if (busy) begin
        if (busyCnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          busyCnt <= busyCnt - CNT_W'(1);
        end
      end

      if (csN) begin
        state  <= S_IDLE;
        txLoad <= 1'b0;
        soOe   <= 1'b0;
      end else if (csFall) begin
        state    <= S_OPC;
        bitCnt   <= '0;
        addrCnt  <= 1'b0;
        dataSeen <= 1'b0;
        statGot  <= 1'b0;
        cancel   <= !wpN;
        txLoad   <= 1'b0;
        soOe     <= 1'b0;
      end else begin
        if (!wpN) cancel <= 1'b1;
        if (strb.shiftIn) bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          case (state)
            S_OPC: begin
              state   <= opNext;
              isWrite <= isOp(rxByte, OP_WRARR);
              txLoad  <= (opNext == S_RDSR);
              if (!busy && isOp(rxByte, OP_SETWEL)) wel <= 1'b1;
              if (!busy && isOp(rxByte, OP_CLRWEL)) wel <= 1'b0;
            end
            S_ADDR: begin
              addrCnt <= addrCnt + 1'b1;
              if (lastAddr) begin
                state  <= isWrite ? S_WR : S_RD;
                txLoad <= !isWrite;
              end
            end
            S_WR:         dataSeen <= 1'b1;
            S_WRSR:       statGot  <= 1'b1;
            S_RD, S_RDSR: txLoad   <= 1'b1;
            default: ;
          endcase
        end
        if (strb.loadArr || strb.loadStat) begin
          txLoad <= 1'b0;
          soOe   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_eeprom_dpath.sv
module spi_eeprom_dpath
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       si,
  input  strobe_t    strb,
  input  logic       wel,
  input  logic       busy,
  output logic [7:0] rxByte,
  output logic       so
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [7:0] rxShift, txShift, statusByte;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic [1:0] bp, bpPend;

  assign rxByte     = {rxShift[6:0], si};
  assign so         = txShift[7];
  assign statusByte = busy ? 8'hFF : {4'b0000, bp, wel, busy};

  function automatic logic isProt(logic [ADDR_W-1:0] a);
    case (bp)
      2'd1:    return a[ADDR_W-1:ADDR_W-2] == 2'b11;
      2'd2:    return a[ADDR_W-1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] pageAddr(int i);
    return {addr[ADDR_W-1:PAGE_W], PAGE_W'(i)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      addr    <= '0;
      pageVld <= '0;
      bp      <= '0;
      bpPend  <= '0;
    end else begin
      if (strb.shiftIn)  rxShift <= rxByte;
      if (strb.addrByte) addr    <= ADDR_W'({addr, rxByte});
      if (strb.pageStart) pageVld <= '0;
      if (strb.dataByte) begin
        pageVld[addr[PAGE_W-1:0]] <= 1'b1;
        addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
      end
      if (strb.statByte)  bpPend <= rxByte[3:2];
      if (strb.writeStat) bp     <= bpPend;
      if (strb.loadArr) begin
        txShift <= mem[addr];
        addr    <= addr + ADDR_W'(1);
      end else if (strb.loadStat) begin
        txShift <= statusByte;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.dataByte) pageBuf[addr[PAGE_W-1:0]] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'h00;
    end else if (strb.commitPage) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageVld[i] && !isProt(pageAddr(i))) mem[pageAddr(i)] <= pageBuf[i];
      end
    end
  end

endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic wpN,
  output logic so,
  output logic soOe
);

  localparam int ADDR_BYTES = (ADDR_W > 8) ? 2 : 1;

  strobe_t    strb;
  logic [7:0] rxByte;
  logic       wel, busy;

  spi_eeprom_ctrl #(
    .ADDR_BYTES  (ADDR_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sck   (sck),
    .wpN   (wpN),
    .rxByte(rxByte),
    .strb  (strb),
    .wel   (wel),
    .busy  (busy),
    .soOe  (soOe)
  );

  spi_eeprom_dpath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .si    (si),
    .strb  (strb),
    .wel   (wel),
    .busy  (busy),
    .rxByte(rxByte),
    .so    (so)
  );

endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic soOe,
  input logic wel,
  input logic busy
);

  // R2: no drive while deselected
  a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && csN) |-> !soOe);

  // R5: latch and busy clear out of reset
  a_r5_clear_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!wel && !busy));

  // R5: a busy period is only entered with the latch set
  a_r5_busy_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  // R8: the busy period starts on the chip select rising edge
  a_r8_busy_at_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csN));

  // R8: the latch is clear once the busy period is over
  a_r8_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R12: the latch cannot be set during the busy period
  a_r12_no_wel_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !$rose(wel));

endmodule

bind spi_eeprom spi_eeprom_chk chk_i (
  .clk (clk),
  .rstN(rstN),
  .csN (csN),
  .soOe(soOe),
  .wel (wel),
  .busy(busy)
);

// File: tb/spi_eeprom_tb_top.sv
module spi_eeprom_tb_top;

  localparam int WCYC = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic wpN = 1'b1;
  logic mode3 = 1'b0;
  wire  so, soOe;
  int   nChk = 0;
  int   nFail = 0;

  always #5 clk = ~clk;

  spi_eeprom #(.ADDR_W(7), .PAGE_BYTES(32), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .so(so), .soOe(soOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait4();
    repeat (4) @(negedge clk);
  endtask

  task automatic waitWrite();
    repeat (WCYC + 20) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                          output logic oeAny);
    rx = '0;
    oeAny = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0;
      si  = tx[i];
      wait4();
      rx[i] = so;
      oeAny = oeAny | soOe;
      sck = 1'b1;
      wait4();
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oeAny);
    xferBits(tx, 8, rx, oeAny);
  endtask

  task automatic csLow();
    @(negedge clk);
    sck = mode3;
    wait4();
    csN = 1'b0;
    wait4();
  endtask

  task automatic csHigh();
    if (!mode3) sck = 1'b0;
    wait4();
    csN = 1'b1;
    wait4();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; logic o;
    csLow(); xfer(op, r, o); csHigh();
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] r; logic o;
    csLow(); xfer(8'h05, r, o); xfer(8'h00, s, o); csHigh();
  endtask

  task automatic writeByte(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r; logic o;
    cmd1(8'h06);
    csLow(); xfer(8'h02, r, o); xfer(a, r, o); xfer(d, r, o); csHigh();
  endtask

  task automatic readByte(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] r; logic o;
    csLow(); xfer(8'h03, r, o); xfer(a, r, o); xfer(8'h00, d, o); csHigh();
  endtask

  task automatic loadStatus(input logic [7:0] v);
    logic [7:0] r; logic o;
    cmd1(8'h06);
    csLow(); xfer(8'h01, r, o); xfer(v, r, o); csHigh();
    waitWrite();
  endtask

  task automatic tReset();
    logic [7:0] r, s; logic o1, o2;
    repeat (5) @(negedge clk);
    check("R4 reset oe", {7'b0, soOe}, 8'h00);
    rstN = 1'b1;
    wait4();
    xfer(8'h05, r, o1); xfer(8'h00, s, o2);
    check("R4 ignored without cs fall", {7'b0, o1 | o2}, 8'h00);
    csHigh();
    readStatus(s);
    check("R9 R5 status after reset", s, 8'h00);
  endtask

  task automatic tLatch();
    logic [7:0] s, d, r; logic o;
    cmd1(8'h0E);
    readStatus(s);
    check("R1 R5 set latch bit3 ignored", s, 8'h02);
    cmd1(8'h04);
    readStatus(s);
    check("R5 clear latch", s, 8'h00);
    csLow(); xfer(8'h02, r, o); xfer(8'h10, r, o); xfer(8'hAA, r, o); csHigh();
    readStatus(s);
    check("R5 write without latch not busy", s, 8'h00);
    readByte(8'h10, d);
    check("R5 write without latch ignored", d, 8'h00);
  endtask

  task automatic tPage();
    logic [7:0] s, r, d0, d1, d2; logic o;
    cmd1(8'h06);
    csLow(); xfer(8'h0A, r, o); xfer(8'h1E, r, o);
    xfer(8'h11, r, o); xfer(8'h22, r, o); xfer(8'h33, r, o); csHigh();
    readStatus(s);
    check("R9 status all ones while busy", s, 8'hFF);
    waitWrite();
    readStatus(s);
    check("R8 latch clear after cycle", s, 8'h00);
    mode3 = 1'b1;
    csLow(); xfer(8'h03, r, o); xfer(8'h9E, r, o);
    xfer(8'h00, d0, o); xfer(8'h00, d1, o); xfer(8'h00, d2, o); csHigh();
    check("R13 R2 mode3 read 1E", d0, 8'h11);
    check("R7 increment 1F", d1, 8'h22);
    check("R6 no spill into 20", d2, 8'h00);
    readByte(8'h00, d0);
    mode3 = 1'b0;
    check("R6 page wrap to 00", d0, 8'h33);
  endtask

  task automatic tRoll();
    logic [7:0] r, d0, d1; logic o;
    writeByte(8'h7F, 8'h5A);
    waitWrite();
    csLow(); xfer(8'h03, r, o); xfer(8'h7F, r, o);
    xfer(8'h00, d0, o); xfer(8'h00, d1, o); csHigh();
    check("R7 last location", d0, 8'h5A);
    check("R7 rollover to 00", d1, 8'h33);
  endtask

  task automatic tInvalid();
    logic [7:0] r, s; logic o1, o2, o3;
    csLow(); xfer(8'h80, r, o1); xfer(8'h03, r, o2); xfer(8'h00, r, o3); csHigh();
    check("R3 bad upper nibble no drive", {7'b0, o1 | o2 | o3}, 8'h00);
    csLow(); xfer(8'h07, r, o1); xfer(8'h00, r, o2); xfer(8'h00, r, o3); csHigh();
    check("R1 R3 code 111 rejected", {7'b0, o1 | o2 | o3}, 8'h00);
    readStatus(s);
    check("R3 recovers on next frame", s, 8'h00);
  endtask

  task automatic tPartial();
    logic [7:0] r, s, d; logic o;
    cmd1(8'h06);
    csLow(); xfer(8'h02, r, o); xfer(8'h40, r, o); xfer(8'h77, r, o);
    xferBits(8'hFF, 3, r, o); csHigh();
    readStatus(s);
    check("R8 partial byte no commit", s, 8'h02);
    readByte(8'h40, d);
    check("R8 partial byte array unchanged", d, 8'h00);
  endtask

  task automatic tWp();
    logic [7:0] r, s, d; logic o;
    cmd1(8'h06);
    csLow(); xfer(8'h02, r, o); xfer(8'h41, r, o); xfer(8'h55, r, o);
    wpN = 1'b0; wait4(); wpN = 1'b1;
    csHigh();
    readStatus(s);
    check("R10 wp pulse cancels", s, 8'h02);
    readByte(8'h41, d);
    check("R10 cancelled byte unchanged", d, 8'h00);
    writeByte(8'h42, 8'h99);
    wpN = 1'b0;
    waitWrite();
    wpN = 1'b1;
    readByte(8'h42, d);
    check("R10 wp during busy ignored", d, 8'h99);
  endtask

  task automatic tBusy();
    logic [7:0] r, s, d; logic o1, o2, o3;
    writeByte(8'h43, 8'h3C);
    cmd1(8'h06);
    csLow(); xfer(8'h03, r, o1); xfer(8'h43, r, o2); xfer(8'h00, d, o3); csHigh();
    check("R12 read during busy no drive", {7'b0, o1 | o2 | o3}, 8'h00);
    waitWrite();
    readStatus(s);
    check("R12 latch set ignored during busy", s, 8'h00);
    readByte(8'h43, d);
    check("R12 earlier write intact", d, 8'h3C);
  endtask

  task automatic tProtect();
    logic [7:0] s, d;
    loadStatus(8'h0C);
    readStatus(s);
    check("R9 protect level in status", s, 8'h0C);
    writeByte(8'h05, 8'hEE); waitWrite();
    readByte(8'h05, d);
    check("R11 level 3 blocks all", d, 8'h00);
    loadStatus(8'h04);
    writeByte(8'h60, 8'hAB); waitWrite();
    readByte(8'h60, d);
    check("R11 level 1 blocks top quarter", d, 8'h00);
    writeByte(8'h20, 8'hCD); waitWrite();
    readByte(8'h20, d);
    check("R11 level 1 allows low half", d, 8'hCD);
    loadStatus(8'h08);
    writeByte(8'h44, 8'h12); waitWrite();
    readByte(8'h44, d);
    check("R11 level 2 blocks top half", d, 8'h00);
    writeByte(8'h3F, 8'h21); waitWrite();
    readByte(8'h3F, d);
    check("R11 level 2 allows 3F", d, 8'h21);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    tReset();
    tLatch();
    tPage();
    tRoll();
    tInvalid();
    tPartial();
    tWp();
    tBusy();
    tProtect();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule